// File: doc/BRIEF.md
# Smart Card Session Sequencer

This block powers a contact smart card up and down in timed steps. A host asks for a card session by pulling an active-low command low. If a debounced card is present and no fault flag is raised, the block turns on, in order, the card supply, the I/O buffer, the card clock and finally the reset pass-through. From then on the card reset follows the host's reset request without inversion. When the command is released, the same steps are undone in reverse: the card reset goes low first, then the clock stops, then I/O is forced low, then the supply goes off.

Step timing comes from a slow internal tick that is divided down from the system clock. Each step waits a fixed number of ticks. Because a step can start anywhere inside a tick period, each interval is exact only to within one tick. An overcurrent, overtemperature or supply-drop flag, or the loss of the debounced card-present signal, starts an emergency deactivation during a session. The status line is active low and carries two meanings: it is low while the card is absent and during an emergency shutdown. Once the block is back in the inactive state, the line is checked again. If it returns high, the card is still there and the shutdown was caused by a hardware fault. If it stays low, the card was removed.

Top module: `card_session_seq`

## Requirements
- R1: Reset state: during and after reset, `vcc_en`, `io_en`, `clk_en` and `card_rst` are 0. `status_n` is 0 until a present card has passed the debouncer.
- R2: `sess_req_n` passes through a two-stage synchroniser. Activation starts only on its high-to-low transition, only from the inactive state, and only while the card is present and no fault flag is set.
- R3: Activation turns on `vcc_en`, then `io_en`, then `clk_en`, then the reset pass-through. A lower step is never off while a higher step is on. The time from one step to the next is STEP_TICKS ticks, between (STEP_TICKS-1)*TICK_DIV and STEP_TICKS*TICK_DIV+1 clock cycles.
- R4: `card_rst` equals `rst_req` while all four steps are on, and is 0 at every other time.
- R5: Releasing `sess_req_n` (low to high) during a session drives `card_rst` low within 4 cycles while `clk_en` is still 1. After that, clock, I/O and supply turn off in that order, one step every STEP_TICKS ticks.
- R6: Any of `flt_oc`, `flt_ot` or `flt_supply` set during a session drives `card_rst` low on the next clock edge. The reverse steps then run down to the inactive state.
- R7: Loss of the debounced card presence during a session starts the same emergency deactivation.
- R8: A change of `card_present_raw` is accepted only after DEB_TICKS consecutive ticks at the new level. A shorter glitch leaves `status_n` unchanged.
- R9: `status_n` is low while the debounced card is absent, and low from the start of an emergency shutdown until the inactive state is reached. In the inactive state it is high again if the card is present, which marks a hardware fault, and it stays low if the card was removed.
- R10: A command transition that occurs before the deactivation reaches the inactive state is ignored. A new high-to-low transition is needed afterwards.
- R11: No activation happens while the debounced card is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sess_req_n | input | 1 | Session command, active low, asynchronous |
| card_present_raw | input | 1 | Raw card presence contact, 1 = card inserted |
| rst_req | input | 1 | Card reset request from host |
| flt_oc | input | 1 | Overcurrent flag |
| flt_ot | input | 1 | Overtemperature flag |
| flt_supply | input | 1 | Supply drop flag |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | I/O buffer enable (0 = forced low) |
| clk_en | output | 1 | Card clock enable (0 = held low) |
| card_rst | output | 1 | Card reset line |
| status_n | output | 1 | Multiplexed status, low = card absent or emergency shutdown |

## Verification
Full sessions are ended in five different ways: a host release, a card removal, and each of the three fault flags. The status level seen at the inactive state tells a removal apart from a hardware fault, and the response latency tells the synchronised host path apart from the direct fault path. Presence glitches shorter than the debounce window are compared with long changes to separate filtering from acceptance. A command that is re-asserted during deactivation, and a command given with no card, show that activation needs a fresh edge from the inactive state with a card present.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
  // Step level; the order is the power-up order and is decoded by the outputs.
  typedef enum logic [2:0] {
    L_OFF = 3'd0,
    L_VCC = 3'd1,
    L_IO  = 3'd2,
    L_CLK = 3'd3,
    L_ACT = 3'd4
  } lvl_e;
endpackage

// File: rtl/cs_sync2.sv
module cs_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cs_tick_gen.sv
module cs_tick_gen #(
  parameter int TICK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
  assign tick = (cnt == LAST);
endmodule

// File: rtl/cs_presence_filter.sv
module cs_presence_filter #(
  parameter int DEB_TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic stable
);
  localparam int CW = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      stable <= 1'b0;
    end else if (raw == stable) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == LAST) begin
        cnt    <= '0;
        stable <= raw;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8
  deb_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stable) |-> $past(tick));
endmodule

// File: rtl/cs_step_fsm.sv
module cs_step_fsm
  import card_seq_pkg::*;
#(
  parameter int STEP_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cmd_act,
  input  logic cmd_edge,
  input  logic present,
  input  logic fault_any,
  output lvl_e lvl,
  output logic emerg
);
  localparam int TW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(STEP_TICKS - 1);

  logic [TW-1:0] tmr;
  logic          up;
  logic          stop;

  assign stop = !cmd_act || !present || fault_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= L_OFF;
      up  <= 1'b0;
      tmr <= '0;
    end else if (lvl == L_OFF) begin
      tmr <= '0;
      if (cmd_edge && present && !fault_any) begin
        lvl <= L_VCC;
        up  <= 1'b1;
      end
    end else if (up && stop) begin
      up  <= 1'b0;
      tmr <= '0;
      lvl <= lvl_e'(lvl - 3'd1);
    end else if (tick) begin
      if (tmr == LAST) begin
        tmr <= '0;
        if (!up)               lvl <= lvl_e'(lvl - 3'd1);
        else if (lvl != L_ACT) lvl <= lvl_e'(lvl + 3'd1);
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      emerg <= 1'b0;
    else if (lvl == L_OFF)           emerg <= 1'b0;
    else if (!present || fault_any)  emerg <= 1'b1;
  end

  // R3
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != $past(lvl)) |-> ((3'(lvl) == 3'($past(lvl)) + 3'd1) || (3'(lvl) + 3'd1 == 3'($past(lvl)))));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == L_OFF && !cmd_edge) |=> lvl == L_OFF);
  // R6
  fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == L_ACT && fault_any) |=> lvl == L_CLK);
endmodule

// File: rtl/card_session_seq.sv
module card_session_seq
  import card_seq_pkg::*;
#(
  parameter int TICK_DIV   = 8,
  parameter int STEP_TICKS = 4,
  parameter int DEB_TICKS  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sess_req_n,
  input  logic card_present_raw,
  input  logic rst_req,
  input  logic flt_oc,
  input  logic flt_ot,
  input  logic flt_supply,
  output logic vcc_en,
  output logic io_en,
  output logic clk_en,
  output logic card_rst,
  output logic status_n
);
  logic [1:0] sync_q;
  logic       tick, cmd_act, cmd_act_d, cmd_edge, present, fault_any, emerg;
  lvl_e       lvl;

  cs_sync2 #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sess_req_n, card_present_raw}), .q(sync_q));

  cs_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  cs_presence_filter #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(sync_q[0]), .stable(present));

  assign cmd_act = !sync_q[1];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_act_d <= 1'b0;
    else        cmd_act_d <= cmd_act;
  end
  assign cmd_edge  = cmd_act && !cmd_act_d;
  assign fault_any = flt_oc || flt_ot || flt_supply;

  cs_step_fsm #(.STEP_TICKS(STEP_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_act(cmd_act), .cmd_edge(cmd_edge),
    .present(present), .fault_any(fault_any), .lvl(lvl), .emerg(emerg));

  assign vcc_en   = (lvl != L_OFF);
  assign io_en    = (lvl >= L_IO);
  assign clk_en   = (lvl >= L_CLK);
  assign card_rst = (lvl == L_ACT) && rst_req;
  assign status_n = present && !emerg;

  // R4
  rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> (rst_req && clk_en));
  // R9
  status_low_emerg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_en && fault_any) |=> !status_n);
endmodule

// File: tb/card_session_seq_test.sv
module card_session_seq_test;
  localparam int D = 8, S = 4, B = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sess_req_n = 1'b1, card_present_raw = 1'b0, rst_req = 1'b1;
  logic flt_oc = 1'b0, flt_ot = 1'b0, flt_supply = 1'b0;
  logic vcc_en, io_en, clk_en, card_rst, status_n;

  int checks = 0, errors = 0, ord_err = 0, cyc = 0;

  always #4 clk = ~clk;

  card_session_seq #(.TICK_DIV(D), .STEP_TICKS(S), .DEB_TICKS(B)) uut (
    .clk(clk), .rst_n(rst_n), .sess_req_n(sess_req_n), .card_present_raw(card_present_raw),
    .rst_req(rst_req), .flt_oc(flt_oc), .flt_ot(flt_ot), .flt_supply(flt_supply),
    .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst), .status_n(status_n));

  // Scenario table: {end kind, expected status_n in inactive state}
  // kind 0 host release, 1 card removal, 2 overcurrent, 3 overtemp, 4 supply drop
  localparam logic [3:0] SCN [5] = '{4'b000_1, 4'b001_0, 4'b010_1, 4'b011_1, 4'b100_1};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return vcc_en;
      1: return io_en;
      2: return clk_en;
      3: return card_rst;
      default: return status_n;
    endcase
  endfunction

  // Wait until sig(sel)==val, return cycles waited or -1 on timeout
  task automatic wait_for(input int sel, input logic val, input int lim, output int n);
    n = 0;
    while (sig(sel) !== val && n < lim) begin
      @(negedge clk);
      n++;
    end
    if (sig(sel) !== val) n = -1;
  endtask

  // Ordering monitor (R3, R5)
  always @(negedge clk) begin
    cyc++;
    if ((io_en && !vcc_en) || (clk_en && !io_en) || (card_rst && !clk_en)) ord_err++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic activate(input bit timed);
    int n;
    sess_req_n = 1'b0;
    wait_for(0, 1'b1, 20, n);
    chk(n >= 0, "R2 supply on after command edge", n, 3);
    for (int s = 1; s < 4; s++) begin
      wait_for(s, 1'b1, S*D + 4, n);
      if (timed)
        chk(n >= (S-1)*D && n <= S*D + 1, "R3 step interval", n, S*D);
      else
        chk(n >= 0, "R3 step reached", n, S*D);
    end
  endtask

  task automatic settle_present(input logic v);
    card_present_raw = v;
    cycles((B+1)*D + 4);
  endtask

  initial begin
    int n;
    cycles(3);
    // R1 reset state
    chk({vcc_en, io_en, clk_en, card_rst} == 4'b0, "R1 enables off in reset", {vcc_en, io_en, clk_en, card_rst}, 0);
    rst_n = 1'b1;
    cycles(2);
    chk(status_n == 1'b0, "R1 status low before card accepted", status_n, 0);
    settle_present(1'b1);
    chk(status_n == 1'b1, "R8 card accepted", status_n, 1);

    // Table walk: R5, R6, R7, R9
    foreach (SCN[i]) begin
      logic [2:0] kind;
      kind = SCN[i][3:1];
      activate(i == 0);
      rst_req = 1'b0; cycles(1);
      chk(card_rst == 1'b0, "R4 follows low request", card_rst, 0);
      rst_req = 1'b1; cycles(1);
      chk(card_rst == 1'b1, "R4 follows high request", card_rst, 1);
      case (kind)
        3'd0: begin
          sess_req_n = 1'b1;
          cycles(4);
          chk(card_rst == 1'b0 && clk_en == 1'b1, "R5 reset drops first", {card_rst, clk_en}, 1);
          chk(status_n == 1'b1, "R9 no alarm on host release", status_n, 1);
        end
        3'd1: begin
          card_present_raw = 1'b0;
          wait_for(4, 1'b0, (B+1)*D + 8, n);
          chk(n >= 0, "R7 removal seen", n, B*D);
          cycles(1);
          chk(card_rst == 1'b0, "R7 removal drops reset", card_rst, 0);
        end
        default: begin
          flt_oc = (kind == 3'd2); flt_ot = (kind == 3'd3); flt_supply = (kind == 3'd4);
          cycles(1);
          chk(card_rst == 1'b0, "R6 fault drops reset next edge", card_rst, 0);
          cycles(1);
          chk(status_n == 1'b0, "R9 status low in emergency", status_n, 0);
        end
      endcase
      for (int s = 2; s >= 0; s--) begin
        wait_for(s, 1'b0, S*D + 4, n);
        if (i == 0) chk(n >= (S-1)*D && n <= S*D + 1, "R5 reverse step interval", n, S*D);
        else        chk(n >= 0, "R6 reverse step reached", n, S*D);
      end
      cycles(3);
      chk(status_n == SCN[i][0], "R9 status after inactive", status_n, SCN[i][0]);
      flt_oc = 1'b0; flt_ot = 1'b0; flt_supply = 1'b0;
      sess_req_n = 1'b1;
      if (kind == 3'd1) settle_present(1'b1);
      cycles(4);
    end

    // R8 short glitch ignored
    card_present_raw = 1'b0;
    cycles(2*D);
    card_present_raw = 1'b1;
    cycles((B+2)*D);
    chk(status_n == 1'b1, "R8 glitch ignored", status_n, 1);
    // R8 long change accepted only after window
    card_present_raw = 1'b0;
    cycles((B-1)*D - 1);
    chk(status_n == 1'b1, "R8 not accepted early", status_n, 1);
    wait_for(4, 1'b0, 2*D + 4, n);
    chk(n >= 0, "R8 accepted after window", n, D);

    // R11 no activation without card
    sess_req_n = 1'b0;
    cycles(3*S*D);
    chk(vcc_en == 1'b0, "R11 refused without card", vcc_en, 0);
    sess_req_n = 1'b1;
    settle_present(1'b1);

    // R10 re-request during deactivation ignored
    activate(1'b0);
    sess_req_n = 1'b1;
    wait_for(3, 1'b0, 8, n);
    cycles(1);
    sess_req_n = 1'b0;
    wait_for(0, 1'b0, 4*S*D, n);
    chk(n >= 0, "R10 deactivation completes", n, 3*S*D);
    cycles(5*S*D);
    chk(vcc_en == 1'b0, "R10 stale request ignored", vcc_en, 0);
    sess_req_n = 1'b1;
    cycles(4);
    sess_req_n = 1'b0;
    wait_for(0, 1'b1, 20, n);
    chk(n >= 0, "R2 fresh edge activates", n, 3);
    sess_req_n = 1'b1;
    wait_for(0, 1'b0, 4*S*D, n);

    chk(ord_err == 0, "R3 step order never violated", ord_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule